// File: doc/BRIEF.md
# Hot-Plug Detect Deglitch Filter

This block cleans up the asynchronous hot-plug-detect line of a display transmitter before the rest of the chip uses it. The raw pin is first brought into the clock domain by a short flip-flop chain. It then passes two filters in series. The first is a short glitch rejector: it accepts a new level only after that level has been held for more than a programmable number of cycles. The second is a long validity qualifier whose hold threshold is counted in units of 1024 cycles.

The qualified level is driven out as a registered status bit. Each rising or falling transition of that level also produces a registered one-cycle event pulse, which an interrupt controller can latch. A single 16-bit configuration word sets both thresholds. The block reads this word on every cycle, so a new setting applies to the next comparison.

Top module: `hpd_deglitch`

## Requirements
- R1: The configuration word holds the glitch threshold N in bits 15:12 and the validity multiplier M in bits 11:0. Both fields are read continuously, and the validity threshold is T = M * 1024 cycles.
- R2: A synchronized level that differs from the glitch stage's current level for N or fewer consecutive cycles is discarded. A difference lasting N+1 cycles is accepted.
- R3: The filtered level takes a new value only after the glitch-filtered level has differed from it for more than T consecutive cycles. A difference of exactly T cycles leaves the filtered level unchanged.
- R4: For a steady change of the raw input, `hpd_level_o` takes the new value on the (3+N+T)-th clock edge after the first edge that samples the new raw value.
- R5: `hpd_rise_o` pulses on the clock edge after `hpd_level_o` goes from 0 to 1, and `hpd_fall_o` pulses on the clock edge after it goes from 1 to 0.
- R6: With N=0 and M=0, the filtered level follows the raw input with a latency of three clock edges.
- R7: The glitch and validity counters restart whenever their input returns to the level they currently hold, so interrupted runs do not add up.
- R8: Each event pulse is exactly one cycle wide, and a rise pulse and a fall pulse never occur in the same cycle.
- R9: While `rst` is high, and on the first cycle after it, `hpd_level_o` is 0 and neither event output is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_raw_i | input | 1 | Asynchronous hot-plug-detect pin |
| cfg_i | input | 16 | Thresholds: N in [15:12], M in [11:0] |
| hpd_level_o | output | 1 | Filtered hot-plug level |
| hpd_rise_o | output | 1 | One-cycle pulse after the filtered level rises |
| hpd_fall_o | output | 1 | One-cycle pulse after the filtered level falls |

## Verification
An input change applied between edges is first sampled on the next edge. The filtered level then moves 3+N+T edges after that sampling edge, and the matching event pulse follows one edge later. For every change it expects to pass, the driver queues the event kind and the exact cycle number computed from N and T. The monitor samples on the falling clock edge, so it reads each pulse in the one cycle it is valid, and it compares that pulse against the head of the queue. Around the validity boundary, the level itself is sampled in the cycle before and the cycle of its due edge. Pulses of exactly N and exactly T cycles queue nothing, so any event they cause shows up as an unexpected entry.

// File: rtl/hpd_filt_pkg.sv
package hpd_filt_pkg;
  localparam int HPD_GLITCH_W   = 4;
  localparam int HPD_VALID_W    = 12;
  localparam int HPD_SCALE_LOG2 = 10;

  typedef enum logic [1:0] {
    EVT_NONE = 2'b00,
    EVT_RISE = 2'b01,
    EVT_FALL = 2'b10
  } hpd_evt_e;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic dout_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din_i};
  end

  assign dout_o = chain_q[STAGES-1];

  // R9: chain flushed by reset
  assert_sync_reset_R9: assert property (@(posedge clk) rst |=> (dout_o == 1'b0));
endmodule

// File: rtl/hpd_persist.sv
// Holds a level and moves it to the input only after the input has
// differed for limit_i+1 consecutive cycles; any return restarts the run.
module hpd_persist #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             lvl_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs;
  logic             done;

  assign differs = (din_i != lvl_q);
  assign done    = (cnt_q >= limit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (done) begin
      lvl_q <= din_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  // R2 / R3: the held level only ever moves toward the previous input
  assert_change_follows_input_R3: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> ($past(din_i) == lvl_q));

  // R2 / R3: a move needs the run counter to have reached the threshold
  assert_change_needs_full_run_R2: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) >= $past(limit_i)));

  // R7: a return to the held level restarts the run
  assert_restart_on_return_R7: assert property (@(posedge clk) disable iff (rst)
    (din_i == lvl_q) |=> (cnt_q == '0));
endmodule

// File: rtl/hpd_edge_evt.sv
module hpd_edge_evt
  import hpd_filt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic     prev_q;
  logic     rise_q;
  logic     fall_q;
  hpd_evt_e evt_d;

  always_comb begin
    evt_d = EVT_NONE;
    if (lvl_i && !prev_q)      evt_d = EVT_RISE;
    else if (!lvl_i && prev_q) evt_d = EVT_FALL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      rise_q <= (evt_d == EVT_RISE);
      fall_q <= (evt_d == EVT_FALL);
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_evt_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_q, fall_q}));
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);
  assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
    fall_q |=> !fall_q);
endmodule

// File: rtl/hpd_deglitch.sv
module hpd_deglitch
  import hpd_filt_pkg::*;
#(
  parameter int GLITCH_W    = HPD_GLITCH_W,
  parameter int VALID_W     = HPD_VALID_W,
  parameter int SCALE_LOG2  = HPD_SCALE_LOG2,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = GLITCH_W + VALID_W,
  localparam int VCNT_W     = VALID_W + SCALE_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hpd_raw_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             hpd_level_o,
  output logic             hpd_rise_o,
  output logic             hpd_fall_o
);
  logic                sync_lvl;
  logic                glitch_lvl;
  logic                valid_lvl;
  logic [GLITCH_W-1:0] glitch_lim;
  logic [VCNT_W-1:0]   valid_lim;

  // R1: field split of the configuration word
  assign glitch_lim = cfg_i[CFG_W-1 -: GLITCH_W];
  assign valid_lim  = {cfg_i[VALID_W-1:0], {SCALE_LOG2{1'b0}}};

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din_i  (hpd_raw_i),
    .dout_o (sync_lvl)
  );

  hpd_persist #(.CNT_W(GLITCH_W)) u_glitch (
    .clk     (clk),
    .rst     (rst),
    .din_i   (sync_lvl),
    .limit_i (glitch_lim),
    .lvl_o   (glitch_lvl)
  );

  hpd_persist #(.CNT_W(VCNT_W)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .din_i   (glitch_lvl),
    .limit_i (valid_lim),
    .lvl_o   (valid_lvl)
  );

  hpd_edge_evt u_evt (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (valid_lvl),
    .rise_o (hpd_rise_o),
    .fall_o (hpd_fall_o)
  );

  assign hpd_level_o = valid_lvl;

  assert_rise_after_level_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_lvl) |=> hpd_rise_o);
  assert_fall_after_level_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_lvl) |=> hpd_fall_o);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!hpd_level_o && !hpd_rise_o && !hpd_fall_o));
endmodule

// File: tb/hpd_deglitch_tb_top.sv
module hpd_deglitch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hpd_raw = 1'b0;
  logic [15:0] cfg = '0;
  logic        lvl, rise, fall;

  always #4 clk = ~clk;

  hpd_deglitch dut_i (
    .clk         (clk),
    .rst         (rst),
    .hpd_raw_i   (hpd_raw),
    .cfg_i       (cfg),
    .hpd_level_o (lvl),
    .hpd_rise_o  (rise),
    .hpd_fall_o  (fall)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit is_rise;
    int due;
  } exp_t;
  exp_t sb[$];

  int  n_chk = 0;
  int  n_bad = 0;
  int  cur_n = 0;
  int  cur_t = 0;
  bit  done  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R1: N goes to bits 15:12, M to bits 11:0; T = M*1024
  task automatic set_cfg(input int n, input int m);
    @(negedge clk);
    cfg   = {4'(n), 12'(m)};
    cur_n = n;
    cur_t = m * 1024;
  endtask

  // Drive a level for 'hold' cycles; queue its event when it should pass (R4)
  task automatic drive(input bit v, input int hold, input bit expect_evt);
    @(negedge clk);
    hpd_raw = v;
    if (expect_evt) sb.push_back('{v, cyc + 5 + cur_n + cur_t});
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic drain(input int n, input string req);
    repeat (n) @(negedge clk);
    check(sb.size() == 0, req, "pending expected events", sb.size(), 0);
  endtask

  // Monitor: compares every event pulse with the scoreboard head
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rise && fall) check(0, "R8", "rise and fall together", 1, 0);
      if (rise || fall) begin
        if (sb.size() == 0) begin
          check(0, "R2/R3", "unexpected event at cycle", cyc, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.is_rise == rise, "R5", "event kind (1=rise)", int'(rise), int'(e.is_rise));
          check(e.due == cyc, "R4", "event cycle", cyc, e.due);
          check(lvl == e.is_rise, "R5", "level at event", int'(lvl), int'(e.is_rise));
        end
      end
    end
  end

  initial begin
    int c0;
    // R9: reset state, raw held high during reset
    hpd_raw = 1'b1;
    repeat (4) @(negedge clk);
    check(!lvl && !rise && !fall, "R9", "outputs in reset", {lvl, rise, fall}, 0);
    hpd_raw = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!lvl && !rise && !fall, "R9", "outputs after reset", {lvl, rise, fall}, 0);

    // R6: N=0, M=0 pass-through with pipeline latency only
    set_cfg(0, 0);
    drive(1'b1, 20, 1'b1);
    drive(1'b0, 20, 1'b1);
    drive(1'b1, 2, 1'b1);
    drive(1'b0, 20, 1'b1);
    drain(10, "R6");

    // R2: N=3, pulses of 3 dropped, of 4 accepted
    set_cfg(3, 0);
    drive(1'b1, 3, 1'b0);
    drive(1'b0, 30, 1'b0);
    drain(5, "R2");
    drive(1'b1, 4, 1'b1);
    drive(1'b0, 30, 1'b1);
    drain(5, "R2");
    // R7: split runs of 2+2 do not add up to 4
    drive(1'b1, 2, 1'b0);
    drive(1'b0, 1, 1'b0);
    drive(1'b1, 2, 1'b0);
    drive(1'b0, 30, 1'b0);
    drain(5, "R7");

    // R3/R4: N=2, M=1 (T=1024), boundary of the qualification time
    set_cfg(2, 1);
    @(negedge clk);
    hpd_raw = 1'b1;
    c0 = cyc;
    sb.push_back('{1'b1, c0 + 5 + cur_n + cur_t});
    while (cyc != c0 + 3 + cur_n + cur_t) @(negedge clk);
    check(lvl == 1'b0, "R3", "level one edge before due", int'(lvl), 0);
    @(negedge clk);
    check(lvl == 1'b1, "R4", "level on due edge", int'(lvl), 1);
    repeat (20) @(negedge clk);
    drive(1'b0, 1024, 1'b0);
    drive(1'b1, 60, 1'b0);
    drain(5, "R3");
    check(lvl == 1'b1, "R3", "level after T-cycle low run", int'(lvl), 1);
    drive(1'b0, 1025, 1'b1);
    drive(1'b1, 1100, 1'b1);
    drain(5, "R3");
    // R7: 600 low, 10 high, 600 low never qualifies
    drive(1'b0, 600, 1'b0);
    drive(1'b1, 10, 1'b0);
    drive(1'b0, 600, 1'b0);
    drive(1'b1, 60, 1'b0);
    drain(5, "R7");
    check(lvl == 1'b1, "R7", "level after split low runs", int'(lvl), 1);
    drive(1'b0, 1100, 1'b1);
    drain(10, "R4");
    check(lvl == 1'b0, "R4", "final level", int'(lvl), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule